// File: doc/BRIEF.md
# Bubble-Collapsing Elastic Shift Pipeline

This block is a chain of equal storage stages that carries data words from a producer to a consumer. Each stage holds one word and one occupancy flag. A valid/ready handshake sits on each side. The producer does not have to offer a word on every cycle, so empty slots enter the chain.

The chain does not let those empty slots pile up behind a stalled consumer. A stage advances whenever the consumer is taking data, and also whenever some stage at or after it is empty. When the consumer stalls, the held words therefore close up towards the output. New words keep being accepted until every stage is occupied.

The word width and the number of stages are parameters. The default is 16 stages of 200 bits. Words pass through unchanged and in arrival order.

Top module: `shpipe_elastic`

## Requirements
- R1: After a synchronous active-high reset, every stage is empty. `out_valid` is low, and `in_ready` is high even while `out_ready` is low.
- R2: Words leave through the output in the order they were accepted at the input. No word is lost and no word is duplicated.
- R3: A stage loads from its left neighbour when `out_ready` is high, or when that stage or any stage after it is empty. The first stage loads from the input port. Into an otherwise empty chain with the output stalled, an accepted word reaches the output after exactly STAGES clock edges.
- R4: `in_ready` is high whenever `out_ready` is high.
- R5: While the output is stalled, `in_ready` stays high as long as at least one stage is empty. The gaps collapse, and the chain fills to STAGES words.
- R6: When all stages are occupied and `out_ready` is low, `in_ready` is low and no stage changes.
- R7: The number of occupied stages never exceeds STAGES. It changes by +1 for each input transfer (`in_valid` and `in_ready` both high) and by -1 for each output transfer (`out_valid` and `out_ready` both high).
- R8: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with the same `out_data`.
- R9: When `in_valid` is low, `in_data` is ignored and only an empty slot enters the chain. Such data never appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Chain accepts the offered word this cycle |
| in_data | input | WIDTH | Offered word |
| out_valid | output | 1 | Last stage holds a word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | WIDTH | Word held in the last stage |

## Verification
The assertions assume the consumer may drop `out_ready` at any cycle. They also assume the producer may raise or drop `in_valid` freely, because the chain itself never requires the producer to hold an offer. They count occupancy only from the cycle after reset is released.

The stimulus drives both handshake inputs only at falling edges. It mixes random valid and ready patterns with directed phases: a stalled fill from empty, a sparse input against a stalled output, a full stall, and a drain. Junk data is driven whenever `in_valid` is low, so any leak of ignored data shows up at the output.

// File: rtl/shpipe_pkg.sv
package shpipe_pkg;

    localparam int DEF_WIDTH  = 200;
    localparam int DEF_STAGES = 16;

    // a handshake transfer happens when both sides agree in the same cycle
    function automatic logic hs_fire(input logic valid, input logic ready);
        return valid & ready;
    endfunction

endpackage

// File: rtl/shpipe_enable.sv
module shpipe_enable #(
    parameter int STAGES = 16
) (
    input  logic [STAGES-1:0] vld,
    input  logic              out_ready,
    output logic [STAGES-1:0] en
);
    localparam int LAST = STAGES - 1;

    // hole[i]: some stage in i..LAST is empty
    logic [STAGES-1:0] hole;

    assign hole[LAST] = ~vld[LAST];

    generate
        for (genvar i = 0; i < LAST; i++) begin : g_hole
            assign hole[i] = ~vld[i] | hole[i+1];
        end
        for (genvar i = 0; i < STAGES; i++) begin : g_en
            assign en[i] = out_ready | hole[i];
        end
    endgenerate

endmodule

// File: rtl/shpipe_slot.sv
module shpipe_slot #(
    parameter int WIDTH = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             d_vld,
    input  logic [WIDTH-1:0] d_dat,
    output logic             q_vld,
    output logic [WIDTH-1:0] q_dat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
        end else if (en) begin
            q_vld <= d_vld;
        end
    end

    // data carries no reset; its content is only meaningful with q_vld
    always_ff @(posedge clk) begin
        if (en) begin
            q_dat <= d_dat;
        end
    end

endmodule

// File: rtl/shpipe_elastic.sv
module shpipe_elastic
    import shpipe_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);
    localparam int LAST  = STAGES - 1;
    localparam int CNT_W = $clog2(STAGES + 1) + 1;

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] dat;
    } slot_t;

    slot_t             cur [STAGES];
    slot_t             feed[STAGES];
    logic [STAGES-1:0] vld_vec;
    logic [STAGES-1:0] en;

    shpipe_enable #(.STAGES(STAGES)) u_enable (
        .vld      (vld_vec),
        .out_ready(out_ready),
        .en       (en)
    );

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign feed[i] = '{vld: in_valid, dat: in_data};
            end else begin : g_body
                assign feed[i] = cur[i-1];
            end

            shpipe_slot #(.WIDTH(WIDTH)) u_slot (
                .clk  (clk),
                .rst  (rst),
                .en   (en[i]),
                .d_vld(feed[i].vld),
                .d_dat(feed[i].dat),
                .q_vld(cur[i].vld),
                .q_dat(cur[i].dat)
            );

            assign vld_vec[i] = cur[i].vld;
        end
    endgenerate

    assign in_ready  = en[0];
    assign out_valid = cur[LAST].vld;
    assign out_data  = cur[LAST].dat;

    // ---------------- assertions ----------------
    logic chk_live = 1'b0;
    always_ff @(posedge clk) chk_live <= ~rst;

    logic [CNT_W-1:0] occ_now;
    assign occ_now = CNT_W'($countones(vld_vec));

    a_r4_ready_pass: assert property (@(posedge clk) disable iff (rst || !chk_live)
        out_ready |-> in_ready);

    a_r5_hole_accepts: assert property (@(posedge clk) disable iff (rst || !chk_live)
        (in_valid && !(&vld_vec)) |-> in_ready);

    a_r6_full_stall: assert property (@(posedge clk) disable iff (rst || !chk_live)
        ((&vld_vec) && !out_ready) |-> !in_ready);

    a_r6_full_hold: assert property (@(posedge clk) disable iff (rst || !chk_live)
        ((&vld_vec) && !out_ready) |=> ((&vld_vec) && $stable(out_data)));

    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst || !chk_live)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r7_count_tracks: assert property (@(posedge clk) disable iff (rst || !chk_live)
        1'b1 |=> (occ_now == $past(occ_now)
                  + CNT_W'($past(hs_fire(in_valid, in_ready)))
                  - CNT_W'($past(hs_fire(out_valid, out_ready)))));

    generate
        for (genvar i = 0; i < LAST; i++) begin : g_chk
            // R3: with the consumer taking data, every held word moves one stage on
            a_r3_advance: assert property (@(posedge clk) disable iff (rst || !chk_live)
                (cur[i].vld && out_ready) |=> (cur[i+1].vld && cur[i+1].dat == $past(cur[i].dat)));
        end
    endgenerate

endmodule

// File: tb/shpipe_elastic_test.sv
module shpipe_elastic_test;
    localparam int W = 16;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;

    always #4 clk = ~clk;

    shpipe_elastic #(.WIDTH(W), .STAGES(N)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] expq[$];
    int           occ = 0;
    logic [W-1:0] next_word = 16'h0100;
    bit           hold_pend = 0;
    logic [W-1:0] hold_val;
    bit           done = 0;
    int           delivered = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, judge just after it, model the coming edge
    task automatic step(input bit iv, input bit orr);
        logic [W-1:0] exp_w;
        @(negedge clk);
        in_valid  = iv;
        out_ready = orr;
        in_data   = iv ? next_word : 16'hDEAD;
        #1;
        if (hold_pend) begin
            chk(out_valid == 1'b1, "R8", "held out_valid", out_valid, 1);
            chk(out_data == hold_val, "R8", "held out_data", out_data, hold_val);
        end
        chk(in_ready == (orr || occ < N), "R4", "in_ready", in_ready, (orr || occ < N));
        if (!orr && occ < N) chk(in_ready == 1'b1, "R5", "ready with hole", in_ready, 1);
        if (!orr && occ == N) chk(in_ready == 1'b0, "R6", "ready when full", in_ready, 0);
        if (occ == N) chk(out_valid == 1'b1, "R6", "out_valid when full", out_valid, 1);
        if (out_valid && orr) begin
            delivered++;
            if (expq.size() == 0) begin
                chk(1'b0, "R9", "unexpected output word", out_data, 0);
            end else begin
                exp_w = expq.pop_front();
                chk(out_data == exp_w, "R2", "output order", out_data, exp_w);
                occ--;
            end
        end
        if (iv && in_ready) begin
            expq.push_back(next_word);
            next_word++;
            occ++;
        end
        chk(occ <= N, "R7", "occupancy", occ, N);
        hold_pend = out_valid && !orr;
        hold_val  = out_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready stalled empty", in_ready, 1);

        // R3: a lone word walks through an empty chain in STAGES edges
        step(1, 0);
        for (int k = 1; k <= N; k++) begin
            step(0, 0);
            chk(out_valid == (k == N), "R3", "walk latency", out_valid, (k == N));
        end

        // R5 and R9: sparse input against a stalled output collapses the gaps
        for (int k = 0; k < 4 * N; k++) step(k % 3 == 0, 0);
        chk(occ == N, "R5", "chain filled", occ, N);

        // R6: full stall
        for (int k = 0; k < 6; k++) step(1, 0);
        chk(in_ready == 1'b0, "R6", "full in_ready", in_ready, 0);

        // R3: drain one word per cycle
        delivered = 0;
        for (int k = 0; k < N + 2; k++) step(0, 1);
        chk(delivered == N, "R3", "drain count", delivered, N);
        chk(out_valid == 1'b0, "R2", "empty after drain", out_valid, 0);

        // R2 and R7: random valid and ready patterns
        for (int k = 0; k < 3000; k++) step(($urandom % 10) < 6, ($urandom % 10) < 5);
        for (int k = 0; k < 1000; k++) step(($urandom % 10) < 9, ($urandom % 10) < 2);
        for (int k = 0; k < 1000; k++) step(($urandom % 10) < 2, ($urandom % 10) < 9);

        // final drain: every accepted word has come out
        for (int k = 0; k < N + 4; k++) step(0, 1);
        chk(expq.size() == 0, "R2", "words left undelivered", expq.size(), 0);
        chk(out_valid == 1'b0, "R2", "out_valid at end", out_valid, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule